// File: doc/BRIEF.md
# Accumulator ALU with Registered Status Flags

This block is the arithmetic and logic stage of a small accumulator-style datapath. It takes one operand from the working register and another from a register-file location. A three-bit function code and a carry input select the operation. The operations are addition, subtraction, bitwise AND, bitwise OR and a left rotation through the carry. Any other function code passes the register-file operand through unchanged. The result is combinational.

Four status flags are kept in a small register that loads only when the flag-update enable is high. The carry flag holds the carry out of the top bit, or the bit shifted out by the rotation. The digit-carry flag holds the carry from the low nibble into the next bit. The zero flag shows that the result was zero. The overflow flag marks a two's-complement result that is out of range. The surrounding datapath feeds the stored carry back in as the carry input when it needs chained arithmetic.

A destination bit on each operation chooses which of two write-enable strobes is raised: one for the working register, one for the register-file location. The register file, instruction decoding and program sequencing live outside this block.

Top module: `alu_flagged_core`

## Requirements
- R1: Function code 000 gives result = A + B + carry_in, truncated to the operand width. A is the working-register operand and B is the register-file operand.
- R2: Function code 001 gives result = A + ~B + 1, and carry_in is ignored. On a flag update the carry flag becomes 1 when A >= B as unsigned values (no borrow) and 0 otherwise.
- R3: Function code 010 gives A AND B. Function code 011 gives A OR B.
- R4: Function code 100 gives result = {B[6:0], carry_in}. On a flag update the carry flag takes the old B[7].
- R5: Function codes 101, 110 and 111 return B unchanged.
- R6: On a flag update the zero flag becomes 1 exactly when the result of that operation is zero. This holds for every function code.
- R7: For addition and subtraction, a flag update sets the digit-carry flag to the carry out of bit 3. This is computed over the same addends the result uses (B inverted and a carry of 1 for subtraction).
- R8: For addition and subtraction, a flag update sets the overflow flag when the carry into bit 7 differs from the carry out of bit 7.
- R9: For AND, OR and pass-through, the carry, digit-carry and overflow flags keep their values. For rotation, the digit-carry and overflow flags keep their values.
- R10: Reset clears all four flags. The flags change only on a rising clock edge with the flag-update enable high, and they appear on the outputs after that edge. With the enable low they hold.
- R11: The destination bit set to 1 raises the register-file write strobe and lowers the working-register strobe. Set to 0 it does the opposite. Both strobes are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| wreg_i | input | 8 | Working-register operand (A) |
| freg_i | input | 8 | Register-file operand (B) |
| func_i | input | 3 | Function code |
| carry_in_i | input | 1 | Carry input for addition and rotation |
| dest_i | input | 1 | Destination bit: 1 register file, 0 working register |
| flag_en_i | input | 1 | Flag-update enable |
| result_o | output | 8 | Combinational result |
| wreg_we_o | output | 1 | Write strobe toward the working register |
| freg_we_o | output | 1 | Write strobe toward the register-file location |
| carry_o | output | 1 | Registered carry flag |
| dcarry_o | output | 1 | Registered digit-carry flag |
| zero_o | output | 1 | Registered zero flag |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The result and both write strobes are combinational, so they are due in the same cycle as the operands. The bench drives every operation on a falling edge and samples these outputs one nanosecond later. The four flags pass through one register and are due after the next rising edge. The bench therefore waits for the following falling edge before it compares them with a flag model, which it advances only when it drove the enable high. Hold behaviour is checked at that same sampling point after operations that would have changed the flags.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [2:0] {
      FN_ADD = 3'b000,
      FN_SUB = 3'b001,
      FN_AND = 3'b010,
      FN_OR  = 3'b011,
      FN_RLC = 3'b100
   } alu_fn_e;

   typedef struct packed {
      logic carry;
      logic dcarry;
      logic zero;
      logic ovf;
   } alu_flags_t;

   localparam alu_flags_t FLAGS_CLEAR = '{carry: 1'b0, dcarry: 1'b0, zero: 1'b0, ovf: 1'b0};

   function automatic logic fn_is_arith(input logic [2:0] fn);
      return (fn == FN_ADD) || (fn == FN_SUB);
   endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH  = 8,
   parameter int NIB    = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             c_msb_in_o,
   output logic             c_nib_o
);

   logic [WIDTH-1:0] addend;
   logic             c0;

   assign addend = sub_i ? ~b_i : b_i;
   assign c0     = sub_i ? 1'b1 : cin_i;

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = c0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i]  = a_i[i] ^ addend[i] ^ cy[i];
            assign cy[i+1]   = (a_i[i] & addend[i]) | (cy[i] & (a_i[i] ^ addend[i]));
         end
         assign cout_o     = cy[WIDTH];
         assign c_msb_in_o = cy[WIDTH-1];
         assign c_nib_o    = cy[NIB];
      end else begin : g_wide
         logic [WIDTH:0] full;
         assign full       = {1'b0, a_i} + {1'b0, addend} + (WIDTH+1)'(c0);
         assign sum_o      = full[WIDTH-1:0];
         assign cout_o     = full[WIDTH];
         // carry into a bit is recovered from the sum bit and both addend bits
         assign c_msb_in_o = full[WIDTH-1] ^ a_i[WIDTH-1] ^ addend[WIDTH-1];
         assign c_nib_o    = full[NIB] ^ a_i[NIB] ^ addend[NIB];
      end
   endgenerate

endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [2:0]       fn_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] res_o,
   output logic             shout_o
);

   assign shout_o = b_i[WIDTH-1];

   always_comb begin
      case (fn_i)
         FN_AND:  res_o = a_i & b_i;
         FN_OR:   res_o = a_i | b_i;
         FN_RLC:  res_o = {b_i[WIDTH-2:0], cin_i};
         default: res_o = b_i;
      endcase
   end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import alu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  alu_flags_t next_i,
   output alu_flags_t q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= FLAGS_CLEAR;
      else if (en_i) q_o <= next_i;
   end

   assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(q_o));

endmodule

// File: rtl/alu_flagged_core.sv
module alu_flagged_core
   import alu_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter int NIB    = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] wreg_i,
   input  logic [WIDTH-1:0] freg_i,
   input  logic [2:0]       func_i,
   input  logic             carry_in_i,
   input  logic             dest_i,
   input  logic             flag_en_i,
   output logic [WIDTH-1:0] result_o,
   output logic             wreg_we_o,
   output logic             freg_we_o,
   output logic             carry_o,
   output logic             dcarry_o,
   output logic             zero_o,
   output logic             ovf_o
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < NIB + 2) begin : g_bad_width
         $error("alu_flagged_core: WIDTH must exceed NIB by at least two");
      end
      if (NIB < 1) begin : g_bad_nib
         $error("alu_flagged_core: NIB must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] sum, lres;
   logic             cout, c_msb_in, c_nib, shout;
   alu_flags_t       flags_q, flags_d;

   alu_adder #(.WIDTH(WIDTH), .NIB(NIB), .RIPPLE(RIPPLE)) u_adder (
      .a_i        (wreg_i),
      .b_i        (freg_i),
      .sub_i      (func_i == FN_SUB),
      .cin_i      (carry_in_i),
      .sum_o      (sum),
      .cout_o     (cout),
      .c_msb_in_o (c_msb_in),
      .c_nib_o    (c_nib)
   );

   alu_logic #(.WIDTH(WIDTH)) u_logic (
      .fn_i    (func_i),
      .a_i     (wreg_i),
      .b_i     (freg_i),
      .cin_i   (carry_in_i),
      .res_o   (lres),
      .shout_o (shout)
   );

   assign result_o  = fn_is_arith(func_i) ? sum : lres;
   assign freg_we_o = dest_i;
   assign wreg_we_o = ~dest_i;

   always_comb begin
      flags_d      = flags_q;
      flags_d.zero = (result_o == '0);
      if (fn_is_arith(func_i)) begin
         flags_d.carry  = cout;
         flags_d.dcarry = c_nib;
         flags_d.ovf    = c_msb_in ^ cout;
      end else if (func_i == FN_RLC) begin
         flags_d.carry  = shout;
      end
   end

   alu_flag_reg u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (flag_en_i),
      .next_i (flags_d),
      .q_o    (flags_q)
   );

   assign carry_o  = flags_q.carry;
   assign dcarry_o = flags_q.dcarry;
   assign zero_o   = flags_q.zero;
   assign ovf_o    = flags_q.ovf;

   assert_add_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (func_i == FN_ADD) |-> result_o == WIDTH'(wreg_i + freg_i + WIDTH'(carry_in_i)));

   assert_rot_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en_i && func_i == FN_RLC) |=> carry_o == $past(freg_i[MSB]));

   assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en_i && result_o == '0) |=> zero_o);

   assert_add_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en_i && func_i == FN_ADD && wreg_i[MSB] == freg_i[MSB] && result_o[MSB] != wreg_i[MSB])
      |=> ovf_o);

   assert_logic_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en_i && (func_i == FN_AND || func_i == FN_OR)) |=> (carry_o == $past(carry_o)) && (ovf_o == $past(ovf_o)));

   assert_dest_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({wreg_we_o, freg_we_o}) == 1);

endmodule

// File: tb/test_alu_flagged_core.sv
`timescale 1ns/1ps
module test_alu_flagged_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] wreg = '0, freg = '0;
   logic [2:0] func = '0;
   logic       cin = 1'b0, dest = 1'b0, fen = 1'b0;
   logic [7:0] result;
   logic       wreg_we, freg_we, carry, dcarry, zero, ovf;

   int tests = 0;
   int fails = 0;

   logic m_c = 0, m_dc = 0, m_z = 0, m_v = 0;

   always #4 clk = ~clk;

   alu_flagged_core i_alu_flagged_core (
      .clk(clk), .rst_n(rst_n), .wreg_i(wreg), .freg_i(freg), .func_i(func),
      .carry_in_i(cin), .dest_i(dest), .flag_en_i(fen), .result_o(result),
      .wreg_we_o(wreg_we), .freg_we_o(freg_we), .carry_o(carry), .dcarry_o(dcarry),
      .zero_o(zero), .ovf_o(ovf));

   task automatic check(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [2:0] f,
                         input logic ci, input logic d, input logic en, input string tag);
      logic [8:0] s;
      logic [4:0] n;
      logic [7:0] r;
      @(negedge clk);
      wreg = a; freg = b; func = f; cin = ci; dest = d; fen = en;
      #1;
      case (f)
         3'd0: begin s = {1'b0,a} + {1'b0,b} + 9'(ci); n = {1'b0,a[3:0]} + {1'b0,b[3:0]} + 5'(ci); r = s[7:0]; end
         3'd1: begin s = {1'b0,a} + {1'b0,~b} + 9'd1; n = {1'b0,a[3:0]} + {1'b0,~b[3:0]} + 5'd1; r = s[7:0]; end
         3'd2: begin s = '0; n = '0; r = a & b; end
         3'd3: begin s = '0; n = '0; r = a | b; end
         3'd4: begin s = '0; n = '0; r = {b[6:0], ci}; end
         default: begin s = '0; n = '0; r = b; end
      endcase
      check({tag, " result"}, result, r);
      check("R11 freg_we", freg_we, d);
      check("R11 wreg_we", wreg_we, !d);
      if (en) begin
         m_z = (r == 8'h00);
         if (f == 3'd0) begin
            m_c = s[8]; m_dc = n[4]; m_v = (a[7] == b[7]) && (r[7] != a[7]);
         end else if (f == 3'd1) begin
            m_c = s[8]; m_dc = n[4]; m_v = (a[7] != b[7]) && (r[7] != a[7]);
         end else if (f == 3'd4) begin
            m_c = b[7];
         end
      end
      @(negedge clk);
      fen = 1'b0;
      check({tag, " carry"}, carry, m_c);
      check("R7 dcarry", dcarry, m_dc);
      check("R6 zero", zero, m_z);
      check("R8 ovf", ovf, m_v);
   endtask

   task automatic t_reset;
      check("R10 reset carry", carry, 0);
      check("R10 reset dcarry", dcarry, 0);
      check("R10 reset zero", zero, 0);
      check("R10 reset ovf", ovf, 0);
   endtask

   task automatic t_add;
      run_op(8'h0F, 8'h01, 3'd0, 0, 0, 1, "R1 add nibble");
      run_op(8'h7F, 8'h01, 3'd0, 0, 1, 1, "R1 add ovf");
      run_op(8'hFF, 8'h01, 3'd0, 0, 0, 1, "R1 add wrap");
      run_op(8'h12, 8'h34, 3'd0, 1, 1, 1, "R1 add cin");
      run_op(8'h80, 8'h80, 3'd0, 0, 0, 1, "R1 add negovf");
   endtask

   task automatic t_sub;
      run_op(8'h05, 8'h03, 3'd1, 0, 0, 1, "R2 sub noborrow");
      run_op(8'h03, 8'h05, 3'd1, 1, 1, 1, "R2 sub borrow");
      run_op(8'h80, 8'h01, 3'd1, 0, 0, 1, "R2 sub ovf");
      run_op(8'h42, 8'h42, 3'd1, 1, 0, 1, "R2 sub equal");
      run_op(8'h10, 8'h01, 3'd1, 0, 1, 1, "R2 sub nib");
   endtask

   task automatic t_logic;
      run_op(8'hFF, 8'h01, 3'd0, 0, 0, 1, "R1 set carry");
      run_op(8'hF0, 8'h0F, 3'd2, 0, 0, 1, "R9 and zero keep");
      run_op(8'hA5, 8'h3C, 3'd2, 1, 1, 1, "R3 and");
      run_op(8'hA0, 8'h05, 3'd3, 0, 0, 1, "R3 or");
   endtask

   task automatic t_rotate;
      run_op(8'h00, 8'h81, 3'd4, 1, 1, 1, "R4 rotate msb");
      run_op(8'h00, 8'h00, 3'd4, 0, 0, 1, "R4 rotate zero");
      run_op(8'h00, 8'h40, 3'd4, 0, 1, 1, "R4 rotate sign");
   endtask

   task automatic t_pass;
      run_op(8'h11, 8'h9C, 3'd5, 1, 0, 1, "R5 pass5");
      run_op(8'h11, 8'h00, 3'd6, 1, 1, 1, "R5 pass6");
      run_op(8'h22, 8'h7E, 3'd7, 0, 0, 1, "R5 pass7");
   endtask

   task automatic t_hold;
      run_op(8'h7F, 8'h01, 3'd0, 0, 0, 1, "R1 prime");
      run_op(8'hFF, 8'h01, 3'd0, 0, 0, 0, "R10 hold add");
      run_op(8'h00, 8'h80, 3'd4, 0, 1, 0, "R10 hold rot");
      run_op(8'h00, 8'h00, 3'd2, 0, 0, 0, "R10 hold and");
   endtask

   initial begin
      #(8 * 100000);
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_add();
      t_sub();
      t_logic();
      t_rotate();
      t_pass();
      t_hold();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule